// File: doc/BRIEF.md
# Multitask Event Sequencer Core

This block is a small microcoded engine that interleaves up to sixteen independent task programs on a single execution path. Each task has a private window of local registers and its own control block (program counter, base offset, status word). All tasks share a bank of global registers and a handful of memory-mapped I/O registers. The I/O registers include an event output, an external input word and a free-running millisecond count. Tasks run triadic instructions: two sources and one destination, where each source may be a local, a global, an I/O register or the instruction's literal. The instruction set also has polling and relative waits, branches, a host interrupt and a halt.

A host loads program memory through a dedicated write port. It reads and writes every local register, every global register and every task's control block through a register port. A task is started by writing its status word with the run bit set, and stopped by clearing that bit. A task emits a timing event by writing a 32-bit word to the event-output register. Each such word enters a small queue, and the queue releases one word per millisecond tick. A task that writes into a full queue is held on that instruction until space frees.

Top module: `mtask_seq_core`

## Requirements
- R1: After reset every task is stopped (status word reads 0), program counters and offsets read 0, local and global registers read 0, and ev_valid and irq_valid are low.
- R2: ALU operations write dst = A op B for ADD, SUB, AND, OR and XOR. MOV copies A, and the indexed move copies the local register whose index is A[4:0]. The operand selector [7:6] gives the kind: 0 local, 1 global, 2 I/O, 3 the 32-bit literal. Any ALU or move sets status bit 2 when its result is zero.
- R3: Each task addresses its own local window, so the same local index in two tasks holds independent values. Global registers are visible to all tasks.
- R4: A round-robin scheduler issues at most one instruction per cycle, and only for a task that is running and not parked. Two always-ready tasks receive issue counts that differ by at most one.
- R5: Instructions are fetched at program counter plus offset. Branch and jump targets are offset-relative, so one program runs unchanged at any base.
- R6: WAITV holds the program counter until A equals B. The task stays running while it waits.
- R7: WAITR A parks the task (status bit 1 set) until the millisecond count reaches the count at arming plus A. The next instruction then sees a count 5 or 6 above a value read just before a 5 ms wait.
- R8: Writing I/O register 0 queues the word. On each millisecond tick the oldest queued word is popped, and it appears on ev_word with ev_valid high one cycle later. Words leave in write order, exactly one tick apart while the queue is non-empty.
- R9: A write to a full queue stalls the writing task without losing or reordering any word. The queue level never exceeds its depth.
- R10: The IRQ instruction raises irq_valid for one cycle in the cycle after issue, with irq_task set to the issuing task and irq_code set to A.
- R11: The host register map is selected by hr_addr[10:9]: 0 local ({task, index}), 1 global, 2 control block ([5:2] task, [1:0] field: 0 pc, 1 offset, 2 status word {zero, wait, run}, 3 deadline). A cycle with hr_we high issues no instruction. STOP clears the run bit and advances the program counter.
- R12: I/O register 1 returns ext_in, 2 the millisecond count (it advances by one every MS_DIV cycles), 3 the issuing task number and 4 the event queue level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_we | input | 1 | Program memory write strobe |
| pm_addr | input | 6 | Program memory word address |
| pm_wdata | input | 60 | Instruction word {op[3:0], dst[7:0], srcA[7:0], srcB[7:0], imm[31:0]} |
| hr_we | input | 1 | Host register write strobe |
| hr_addr | input | 11 | Host register address |
| hr_wdata | input | 32 | Host write data |
| hr_rdata | output | 32 | Host read data, combinational from hr_addr |
| ext_in | input | 32 | External input word seen as an I/O register |
| ev_valid | output | 1 | Event word valid for one cycle |
| ev_word | output | 32 | Emitted event word |
| irq_valid | output | 1 | Host interrupt pulse |
| irq_task | output | 4 | Task that raised the interrupt |
| irq_code | output | 32 | Interrupt code (source A of the IRQ instruction) |

## Verification
Host reads are combinational and are sampled one time unit after the falling edge that sets the address. Host writes and instruction results land on the next rising edge. The bench therefore waits for a task to leave the running state and only then reads its registers through the host port. An event word is due one cycle after the millisecond tick that pops it, and an interrupt one cycle after its IRQ issues. The bench stamps both on the falling edge with a cycle count and checks the spacing between events against MS_DIV, with no absolute tick position assumed. Wait durations are checked through millisecond counts that the task itself samples, and stall behaviour is checked through those counts and through the event order.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_MOV   = 4'd6,
    OP_MOVX  = 4'd7,
    OP_WAITV = 4'd8,
    OP_WAITR = 4'd9,
    OP_BEQ   = 4'd10,
    OP_BNE   = 4'd11,
    OP_IRQ   = 4'd12,
    OP_STOP  = 4'd13,
    OP_JMP   = 4'd14
  } op_e;

  typedef enum logic [1:0] {
    K_LOC = 2'd0,
    K_GLB = 2'd1,
    K_IO  = 2'd2,
    K_LIT = 2'd3
  } kind_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  dst;
    logic [7:0]  sa;
    logic [7:0]  sb;
    logic [31:0] imm;
  } instr_t;

  localparam int IW = $bits(instr_t);

  localparam logic [2:0] IO_EVOUT  = 3'd0;
  localparam logic [2:0] IO_EXTIN  = 3'd1;
  localparam logic [2:0] IO_MSCNT  = 3'd2;
  localparam logic [2:0] IO_TASKID = 3'd3;
  localparam logic [2:0] IO_QLVL   = 3'd4;

  // Two-source arithmetic and logic; moves pass A through.
  function automatic logic [31:0] alu_eval(input op_e op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      default: r = a;
    endcase
    return r;
  endfunction

  // Wrap-safe "now has reached deadline" test on the millisecond count.
  function automatic logic ms_reached(input logic [31:0] now, input logic [31:0] dl);
    logic [31:0] d;
    d = now - dl;
    return !d[31];
  endfunction

  function automatic logic is_datapath(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR) ||
           (op == OP_XOR) || (op == OP_MOV) || (op == OP_MOVX);
  endfunction

endpackage

// File: rtl/mts_mstimer.sv
module mts_mstimer #(
  parameter int MS_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ms_tick,
  output logic [31:0] ms_cnt
);
  localparam int PRW = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;

  logic [PRW-1:0] pre;

  assign ms_tick = (pre == PRW'(MS_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      ms_cnt <= '0;
    end else if (ms_tick) begin
      pre    <= '0;
      ms_cnt <= ms_cnt + 32'd1;
    end else begin
      pre <= pre + PRW'(1);
    end
  end
endmodule

// File: rtl/mts_sched.sv
module mts_sched #(
  parameter int NTASK = 16,
  localparam int TW = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTASK-1:0] ready,
  input  logic             take,
  output logic             grant_valid,
  output logic [TW-1:0]    grant_id
);
  logic [TW-1:0] last;

  // Search starts one past the last served task and wraps around.
  always_comb begin
    grant_valid = 1'b0;
    grant_id    = last;
    for (int k = 1; k <= NTASK; k++) begin
      logic [TW-1:0] idx;
      idx = TW'((int'(last) + k) % NTASK);
      if (!grant_valid && ready[idx]) begin
        grant_valid = 1'b1;
        grant_id    = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last <= TW'(NTASK - 1);
    else if (take) last <= grant_id;
  end
endmodule

// File: rtl/mts_evq.sv
module mts_evq #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   din,
  input  logic          pop,
  output logic [31:0]   dout,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mtask_seq_core.sv
module mtask_seq_core
  import mts_pkg::*;
#(
  parameter int NTASK     = 16,
  parameter int NLOC      = 32,
  parameter int NGLB      = 16,
  parameter int PDEPTH    = 64,
  parameter int MS_DIV    = 20,
  parameter int EVQ_DEPTH = 4,
  localparam int TW  = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int LW  = $clog2(NLOC),
  localparam int GW  = $clog2(NGLB),
  localparam int PW  = $clog2(PDEPTH),
  localparam int HAW = 2 + TW + LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pm_we,
  input  logic [PW-1:0]  pm_addr,
  input  logic [IW-1:0]  pm_wdata,
  input  logic           hr_we,
  input  logic [HAW-1:0] hr_addr,
  input  logic [31:0]    hr_wdata,
  output logic [31:0]    hr_rdata,
  input  logic [31:0]    ext_in,
  output logic           ev_valid,
  output logic [31:0]    ev_word,
  output logic           irq_valid,
  output logic [TW-1:0]  irq_task,
  output logic [31:0]    irq_code
);
  localparam int QCW = $clog2(EVQ_DEPTH + 1);

  // Storage
  logic [IW-1:0] pmem [PDEPTH];
  logic [31:0]   lreg [NTASK*NLOC];
  logic [31:0]   greg [NGLB];
  logic [PW-1:0] t_pc  [NTASK];
  logic [PW-1:0] t_off [NTASK];
  logic          t_run [NTASK];
  logic          t_wait[NTASK];
  logic          t_zero[NTASK];
  logic [31:0]   t_dl  [NTASK];
  logic [31:0]   ev_last;

  // Named internal events (observed by the checker)
  logic             ms_tick;
  logic [31:0]      ms_cnt;
  logic [NTASK-1:0] ready;
  logic             grant_valid;
  logic [TW-1:0]    cur;
  logic             issue;
  logic             push_req, push, stall;
  logic             q_full, q_empty;
  logic [QCW-1:0]   q_lvl;
  logic [31:0]      q_dout;

  // Execute-stage decode
  instr_t        ins;
  logic [PW-1:0] fetch_addr, nxt_pc;
  logic [31:0]   va, vb, res;
  logic          adv, wb, arm, disarm, halt, irq_fire;
  kind_e         dkind;

  mts_mstimer #(.MS_DIV(MS_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ms_cnt(ms_cnt)
  );

  for (genvar g = 0; g < NTASK; g++) begin : g_rdy
    assign ready[g] = t_run[g] && (!t_wait[g] || ms_reached(ms_cnt, t_dl[g]));
  end

  assign issue = grant_valid && !hr_we;

  mts_sched #(.NTASK(NTASK)) u_sched (
    .clk(clk), .rst_n(rst_n), .ready(ready), .take(issue),
    .grant_valid(grant_valid), .grant_id(cur)
  );

  mts_evq #(.DEPTH(EVQ_DEPTH)) u_evq (
    .clk(clk), .rst_n(rst_n), .push(push), .din(res), .pop(ms_tick),
    .dout(q_dout), .level(q_lvl), .full(q_full), .empty(q_empty)
  );

  assign fetch_addr = t_pc[cur] + t_off[cur];
  assign ins        = instr_t'(pmem[fetch_addr]);

  function automatic logic [31:0] opnd(input logic [7:0] s);
    logic [31:0] v;
    case (kind_e'(s[7:6]))
      K_LOC: v = lreg[{cur, s[LW-1:0]}];
      K_GLB: v = greg[s[GW-1:0]];
      K_IO: begin
        case (s[2:0])
          IO_EVOUT:  v = ev_last;
          IO_EXTIN:  v = ext_in;
          IO_MSCNT:  v = ms_cnt;
          IO_TASKID: v = 32'(cur);
          IO_QLVL:   v = 32'(q_lvl);
          default:   v = '0;
        endcase
      end
      default: v = ins.imm;
    endcase
    return v;
  endfunction

  always_comb begin
    va  = opnd(ins.sa);
    vb  = opnd(ins.sb);
    res = (ins.op == OP_MOVX) ? lreg[{cur, va[LW-1:0]}] : alu_eval(ins.op, va, vb);
  end

  always_comb begin
    adv      = 1'b1;
    nxt_pc   = t_pc[cur] + PW'(1);
    wb       = is_datapath(ins.op);
    arm      = 1'b0;
    disarm   = 1'b0;
    halt     = 1'b0;
    irq_fire = 1'b0;
    dkind    = kind_e'(ins.dst[7:6]);
    case (ins.op)
      OP_WAITV: adv = (va == vb);
      OP_WAITR: begin
        if (!t_wait[cur]) begin adv = 1'b0; arm = 1'b1; end
        else disarm = 1'b1;
      end
      OP_BEQ:  if (va == vb) nxt_pc = ins.imm[PW-1:0];
      OP_BNE:  if (va != vb) nxt_pc = ins.imm[PW-1:0];
      OP_JMP:  nxt_pc = ins.imm[PW-1:0];
      OP_IRQ:  irq_fire = 1'b1;
      OP_STOP: halt = 1'b1;
      default: ;
    endcase
    push_req = wb && (dkind == K_IO) && (ins.dst[2:0] == IO_EVOUT);
    stall    = push_req && q_full;
    if (stall) adv = 1'b0;
  end

  assign push = issue && push_req && !q_full;

  always_ff @(posedge clk) begin
    if (pm_we) pmem[pm_addr] <= pm_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTASK; t++) begin
        t_pc[t] <= '0; t_off[t] <= '0; t_run[t] <= 1'b0;
        t_wait[t] <= 1'b0; t_zero[t] <= 1'b0; t_dl[t] <= '0;
      end
      for (int i = 0; i < NTASK*NLOC; i++) lreg[i] <= '0;
      for (int i = 0; i < NGLB; i++) greg[i] <= '0;
      ev_last   <= '0;
      irq_valid <= 1'b0;
      irq_task  <= '0;
      irq_code  <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (hr_we) begin
        case (hr_addr[HAW-1:HAW-2])
          2'd0: lreg[hr_addr[TW+LW-1:0]] <= hr_wdata;
          2'd1: greg[hr_addr[GW-1:0]] <= hr_wdata;
          2'd2: begin
            case (hr_addr[1:0])
              2'd0: t_pc[hr_addr[TW+1:2]]  <= hr_wdata[PW-1:0];
              2'd1: t_off[hr_addr[TW+1:2]] <= hr_wdata[PW-1:0];
              2'd2: begin
                t_run[hr_addr[TW+1:2]]  <= hr_wdata[0];
                t_wait[hr_addr[TW+1:2]] <= hr_wdata[1];
                t_zero[hr_addr[TW+1:2]] <= hr_wdata[2];
              end
              default: t_dl[hr_addr[TW+1:2]] <= hr_wdata;
            endcase
          end
          default: ;
        endcase
      end else if (issue) begin
        if (adv)    t_pc[cur] <= nxt_pc;
        if (arm)    begin t_wait[cur] <= 1'b1; t_dl[cur] <= ms_cnt + va; end
        if (disarm) t_wait[cur] <= 1'b0;
        if (halt)   t_run[cur] <= 1'b0;
        if (wb && !stall) begin
          case (dkind)
            K_LOC:   lreg[{cur, ins.dst[LW-1:0]}] <= res;
            K_GLB:   greg[ins.dst[GW-1:0]] <= res;
            default: ;
          endcase
          t_zero[cur] <= (res == '0);
        end
        if (push) ev_last <= res;
        if (irq_fire) begin
          irq_valid <= 1'b1;
          irq_task  <= cur;
          irq_code  <= va;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_word  <= '0;
    end else begin
      ev_valid <= ms_tick && !q_empty;
      if (ms_tick && !q_empty) ev_word <= q_dout;
    end
  end

  always_comb begin
    hr_rdata = '0;
    case (hr_addr[HAW-1:HAW-2])
      2'd0: hr_rdata = lreg[hr_addr[TW+LW-1:0]];
      2'd1: hr_rdata = greg[hr_addr[GW-1:0]];
      2'd2: begin
        case (hr_addr[1:0])
          2'd0:    hr_rdata = 32'(t_pc[hr_addr[TW+1:2]]);
          2'd1:    hr_rdata = 32'(t_off[hr_addr[TW+1:2]]);
          2'd2:    hr_rdata = {29'd0, t_zero[hr_addr[TW+1:2]],
                               t_wait[hr_addr[TW+1:2]], t_run[hr_addr[TW+1:2]]};
          default: hr_rdata = t_dl[hr_addr[TW+1:2]];
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mts_chk.sv
module mts_chk #(
  parameter int NTASK     = 16,
  parameter int EVQ_DEPTH = 4,
  localparam int TW  = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int QCW = $clog2(EVQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [TW-1:0]    issue_task,
  input logic [NTASK-1:0] ready,
  input logic             push,
  input logic             q_full,
  input logic [QCW-1:0]   q_lvl,
  input logic             ms_tick,
  input logic [31:0]      ms_cnt,
  input logic             ev_valid,
  input logic             irq_valid
);
  assert_issue_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ready[issue_task]);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_lvl <= QCW'(EVQ_DEPTH));

  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !ms_tick) |=> (q_lvl == $past(q_lvl)));

  assert_push_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !ms_tick) |=> (q_lvl == $past(q_lvl) + QCW'(1)));

  assert_ev_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(ms_tick));

  assert_irq_after_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(issue));

  assert_ms_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |=> (ms_cnt == $past(ms_cnt) + 32'd1));

  assert_ms_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(ms_cnt));
endmodule

bind mtask_seq_core mts_chk #(.NTASK(NTASK), .EVQ_DEPTH(EVQ_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .issue_task(cur), .ready(ready),
  .push(push), .q_full(q_full), .q_lvl(q_lvl), .ms_tick(ms_tick),
  .ms_cnt(ms_cnt), .ev_valid(ev_valid), .irq_valid(irq_valid)
);

// File: tb/tb_mtask_seq_core.sv
module tb_mtask_seq_core;
  import mts_pkg::*;

  localparam int CLK_P = 10;
  localparam int MSD   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_we = 1'b0;
  logic [5:0]  pm_addr = '0;
  logic [59:0] pm_wdata = '0;
  logic        hr_we = 1'b0;
  logic [10:0] hr_addr = '0;
  logic [31:0] hr_wdata = '0;
  logic [31:0] hr_rdata;
  logic [31:0] ext_in = 32'hCAFE0001;
  logic        ev_valid;
  logic [31:0] ev_word;
  logic        irq_valid;
  logic [3:0]  irq_task;
  logic [31:0] irq_code;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int          evn = 0;
  logic [31:0] evbuf [16];
  int          evcyc [16];
  int          irqn = 0;
  logic [3:0]  irq_t_seen;
  logic [31:0] irq_c_seen;

  mtask_seq_core #(.MS_DIV(MSD)) dut (
    .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .hr_we(hr_we), .hr_addr(hr_addr), .hr_wdata(hr_wdata), .hr_rdata(hr_rdata),
    .ext_in(ext_in), .ev_valid(ev_valid), .ev_word(ev_word),
    .irq_valid(irq_valid), .irq_task(irq_task), .irq_code(irq_code)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && ev_valid && evn < 16) begin
      evbuf[evn] = ev_word;
      evcyc[evn] = cyc;
      evn++;
    end
    if (rst_n && irq_valid) begin
      irq_t_seen = irq_task;
      irq_c_seen = irq_code;
      irqn++;
    end
  end

  // Instruction and address builders
  function automatic logic [59:0] mk(op_e op, logic [7:0] d, logic [7:0] a,
                                     logic [7:0] b, logic [31:0] imm);
    return {op, d, a, b, imm};
  endfunction
  function automatic logic [7:0] L(int n);  return {2'b00, 6'(n)}; endfunction
  function automatic logic [7:0] G(int n);  return {2'b01, 6'(n)}; endfunction
  function automatic logic [7:0] IO(int n); return {2'b10, 6'(n)}; endfunction
  localparam logic [7:0] LIT = 8'hC0;
  function automatic logic [10:0] a_loc(int t, int r); return {2'b00, 4'(t), 5'(r)}; endfunction
  function automatic logic [10:0] a_glb(int g); return {2'b01, 9'(g)}; endfunction
  function automatic logic [10:0] a_tcb(int t, int f); return {2'b10, 3'b0, 4'(t), 2'(f)}; endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ceq(string tag, logic [31:0] act, logic [31:0] exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic pload(int a, logic [59:0] w);
    @(negedge clk); pm_we = 1'b1; pm_addr = 6'(a); pm_wdata = w;
    @(negedge clk); pm_we = 1'b0;
  endtask

  // Back-to-back host writes occupy consecutive cycles; hdone drops the strobe.
  task automatic hwr(logic [10:0] a, logic [31:0] d);
    @(negedge clk); hr_we = 1'b1; hr_addr = a; hr_wdata = d;
  endtask
  task automatic hdone();
    @(negedge clk); hr_we = 1'b0;
  endtask

  task automatic hrd(logic [10:0] a, output logic [31:0] d);
    @(negedge clk); hr_addr = a; #1; d = hr_rdata;
  endtask

  task automatic start_task(int t, int off);
    hwr(a_tcb(t, 1), 32'(off));
    hwr(a_tcb(t, 0), 32'd0);
    hwr(a_tcb(t, 2), 32'd1);
    hdone();
  endtask

  task automatic wait_stop(int t);
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      hrd(a_tcb(t, 2), s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hrd(a_tcb(0, 2), v); ceq("R1 status word", v, 32'd0);
    hrd(a_tcb(9, 0), v); ceq("R1 pc", v, 32'd0);
    hrd(a_loc(3, 7), v); ceq("R1 local", v, 32'd0);
    hrd(a_glb(2), v);    ceq("R1 global", v, 32'd0);
    check(!ev_valid && !irq_valid, "R1 outputs idle", {ev_valid, irq_valid}, 0);
  endtask

  task automatic t_alu();
    logic [31:0] v;
    pload(0,  mk(OP_MOV,  L(1),  LIT,    LIT,   32'd12));
    pload(1,  mk(OP_ADD,  L(2),  L(1),   LIT,   32'd30));
    pload(2,  mk(OP_SUB,  L(3),  L(2),   L(1),  0));
    pload(3,  mk(OP_AND,  L(4),  L(2),   LIT,   32'h0F));
    pload(4,  mk(OP_OR,   L(5),  L(1),   LIT,   32'h100));
    pload(5,  mk(OP_XOR,  L(6),  L(2),   L(1),  0));
    pload(6,  mk(OP_MOV,  G(2),  LIT,    LIT,   32'h55));
    pload(7,  mk(OP_MOV,  L(7),  IO(1),  LIT,   0));
    pload(8,  mk(OP_MOV,  L(8),  LIT,    LIT,   32'd3));
    pload(9,  mk(OP_MOVX, L(9),  L(8),   LIT,   0));
    pload(10, mk(OP_SUB,  L(10), L(1),   L(1),  0));
    pload(11, mk(OP_STOP, LIT,   LIT,    LIT,   0));
    start_task(0, 0);
    wait_stop(0);
    hrd(a_loc(0, 2), v); ceq("R2 add", v, 32'd42);
    hrd(a_loc(0, 3), v); ceq("R2 sub", v, 32'd30);
    hrd(a_loc(0, 4), v); ceq("R2 and", v, 32'h0A);
    hrd(a_loc(0, 5), v); ceq("R2 or", v, 32'h10C);
    hrd(a_loc(0, 6), v); ceq("R2 xor", v, 32'h26);
    hrd(a_glb(2), v);    ceq("R2 global dst", v, 32'h55);
    hrd(a_loc(0, 7), v); ceq("R12 ext_in read", v, 32'hCAFE0001);
    hrd(a_loc(0, 9), v); ceq("R2 indexed move", v, 32'd30);
    hrd(a_tcb(0, 2), v); ceq("R2 zero flag, R11 stop clears run", v, 32'd4);
    hrd(a_tcb(0, 0), v); ceq("R11 pc after stop", v, 32'd12);
  endtask

  task automatic t_windows();
    logic [31:0] v;
    pload(16, mk(OP_MOV,   L(1), LIT,   LIT, 32'h111));
    pload(17, mk(OP_MOV,   G(5), LIT,   LIT, 32'd7));
    pload(18, mk(OP_STOP,  LIT,  LIT,   LIT, 0));
    pload(24, mk(OP_MOV,   L(1), LIT,   LIT, 32'h222));
    pload(25, mk(OP_WAITV, LIT,  G(5),  LIT, 32'd7));
    pload(26, mk(OP_MOV,   L(2), G(5),  LIT, 0));
    pload(27, mk(OP_MOV,   L(3), IO(3), LIT, 0));
    pload(28, mk(OP_STOP,  LIT,  LIT,   LIT, 0));
    start_task(2, 24);
    repeat (30) @(negedge clk);
    hrd(a_tcb(2, 0), v); ceq("R6 pc held while polling", v, 32'd1);
    hrd(a_tcb(2, 2), v); ceq("R6 still running", v, 32'd1);
    hrd(a_loc(2, 2), v); ceq("R6 no progress past wait", v, 32'd0);
    start_task(1, 16);
    wait_stop(1);
    wait_stop(2);
    hrd(a_loc(1, 1), v); ceq("R3 task1 window", v, 32'h111);
    hrd(a_loc(2, 1), v); ceq("R3 task2 window", v, 32'h222);
    hrd(a_loc(0, 1), v); ceq("R3 task0 window untouched", v, 32'd12);
    hrd(a_loc(2, 2), v); ceq("R3 shared global seen", v, 32'd7);
    hrd(a_loc(2, 3), v); ceq("R12 task number", v, 32'd2);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    pload(40, mk(OP_MOV,  L(1), LIT,  LIT,  32'd0));
    pload(41, mk(OP_ADD,  L(1), L(1), LIT,  32'd1));
    pload(42, mk(OP_BNE,  LIT,  L(1), L(4), 32'd1));
    pload(43, mk(OP_STOP, LIT,  LIT,  LIT,  0));
    hwr(a_loc(3, 4), 32'd3);
    hdone();
    start_task(3, 40);
    wait_stop(3);
    hrd(a_loc(3, 1), v); ceq("R5 loop count", v, 32'd3);
    hrd(a_tcb(3, 0), v); ceq("R5 relative pc", v, 32'd4);
  endtask

  task automatic t_events();
    logic [31:0] v, m0, m1;
    int base;
    pload(48, mk(OP_MOV, L(2), IO(2), LIT, 0));
    for (int i = 0; i < 6; i++)
      pload(49 + i, mk(OP_MOV, IO(0), LIT, LIT, 32'hE000_0000 + 32'(i)));
    pload(55, mk(OP_MOV,  L(1), IO(2), LIT, 0));
    pload(56, mk(OP_STOP, LIT,  LIT,   LIT, 0));
    base = evn;
    start_task(4, 48);
    wait_stop(4);
    hrd(a_loc(4, 2), m0);
    hrd(a_loc(4, 1), m1);
    check((m1 - m0) >= 32'd2, "R9 full queue stalled writer", m1 - m0, 32'd2);
    repeat (8 * MSD) @(negedge clk);
    ceq("R9 no word lost", 32'(evn - base), 32'd6);
    for (int i = 0; i < 6; i++)
      ceq("R8 event order", evbuf[base + i], 32'hE000_0000 + 32'(i));
    for (int i = 1; i < 6; i++)
      ceq("R8 one word per tick", 32'(evcyc[base + i] - evcyc[base + i - 1]), 32'(MSD));
  endtask

  task automatic t_waitr_irq();
    logic [31:0] v, m0, m1;
    int n0;
    pload(32, mk(OP_MOV,   L(1), IO(2), LIT, 0));
    pload(33, mk(OP_WAITR, LIT,  LIT,   LIT, 32'd5));
    pload(34, mk(OP_MOV,   L(2), IO(2), LIT, 0));
    pload(35, mk(OP_IRQ,   LIT,  LIT,   LIT, 32'hAB));
    pload(36, mk(OP_STOP,  LIT,  LIT,   LIT, 0));
    n0 = irqn;
    start_task(5, 32);
    repeat (20) @(negedge clk);
    hrd(a_tcb(5, 2), v); ceq("R7 parked status", v, 32'd3);
    hrd(a_tcb(5, 0), v); ceq("R7 pc on wait", v, 32'd1);
    wait_stop(5);
    repeat (3) @(negedge clk);
    hrd(a_loc(5, 1), m0);
    hrd(a_loc(5, 2), m1);
    check((m1 - m0) == 32'd5 || (m1 - m0) == 32'd6, "R7 wait length", m1 - m0, 32'd5);
    ceq("R10 one interrupt", 32'(irqn - n0), 32'd1);
    ceq("R10 interrupt task", 32'(irq_t_seen), 32'd5);
    ceq("R10 interrupt code", irq_c_seen, 32'hAB);
  endtask

  task automatic t_rr();
    logic [31:0] c6, c7;
    pload(12, mk(OP_ADD, L(1), L(1), LIT, 32'd1));
    pload(13, mk(OP_JMP, LIT,  LIT,  LIT, 32'd0));
    hwr(a_tcb(6, 1), 32'd12); hwr(a_tcb(6, 0), 0); hwr(a_tcb(6, 2), 1);
    hwr(a_tcb(7, 1), 32'd12); hwr(a_tcb(7, 0), 0); hwr(a_tcb(7, 2), 1);
    hdone();
    repeat (101) @(negedge clk);
    hwr(a_tcb(6, 2), 0); hwr(a_tcb(7, 2), 0);
    hdone();
    hrd(a_loc(6, 1), c6);
    hrd(a_loc(7, 1), c7);
    check((c6 > c7 ? c6 - c7 : c7 - c6) <= 1, "R4 fair share", c6, c7);
    check(c6 > 20 && c6 < 60, "R4 one issue per cycle", c6, 32'd25);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alu();
    t_windows();
    t_branch();
    t_events();
    t_waitr_irq();
    t_rr();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule